// File: doc/BRIEF.md
# Latched 4-to-16 line decoder

This block selects one of sixteen lines from a 4-bit binary address. The address does not reach the decoder directly. It first passes through a storage register that a strobe input controls. While the strobe is high, the register follows the address. Once the strobe goes low, the register keeps the last address it took.

A blanking input drives every line to its inactive level. It leaves the stored address alone, so the same line comes back when blanking is released. A build-time parameter sets the polarity: the selected line is either high among low lines, or low among high lines.

The model is synchronous. The system clock samples the strobe, and the storage is a register with a load enable. The output stage is combinational from the stored address and the current blanking level. Reset is asserted asynchronously and released synchronously to the clock.

Top module: `latched_line_decoder`

## Requirements
- R1: At each rising clock edge where `strobe` is high, the stored address takes the value on `sel_addr`, and `line_sel` shows the decode of that value from that edge on.
- R2: At each rising clock edge where `strobe` is low, the stored address keeps its value, and changes on `sel_addr` have no effect on `line_sel`.
- R3: While `inhibit` is high, every bit of `line_sel` is at the inactive level: 16'h0000 when ACTIVE_HIGH=1, 16'hFFFF when ACTIVE_HIGH=0.
- R4: Loading and holding continue while `inhibit` is high. When `inhibit` falls, `line_sel` shows the address stored at that point, including any address loaded during blanking.
- R5: While `inhibit` is low, exactly one bit of `line_sel` is at the active level.
- R6: `sel_addr[0]` (A) is the least significant address bit and `sel_addr[3]` (D) is the most significant. The active bit index equals the unsigned address value, so 4'b0001 selects bit 1 and 4'b1111 selects bit 15.
- R7: With ACTIVE_HIGH=1 the selected bit is 1 and the others are 0. With ACTIVE_HIGH=0, `line_sel` is the bitwise inverse of the ACTIVE_HIGH=1 output for the same inputs.
- R8: While `rst_n` is low, the stored address is 0, so with `inhibit` low `line_sel` selects bit 0. This takes effect without waiting for a clock edge.
- R9: A change on `inhibit` reaches `line_sel` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples `strobe` |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| strobe | input | 1 | Load enable for the address register (high = follow, low = hold) |
| inhibit | input | 1 | High forces all select lines to the inactive level |
| sel_addr | input | 4 | Binary address; bit 0 is A (LSB), bit 3 is D (MSB) |
| line_sel | output | 16 | One-of-sixteen select bus; polarity set by ACTIVE_HIGH |

## Verification
The bench walks all sixteen addresses against an active-high and an active-low instance side by side. A swapped or mirrored address bit order would therefore light the wrong line, and a broken inversion would show up as a mismatch on the second instance.

Several corner cases get their own stimulus:
- Address changes are applied while the strobe is low. A register that stayed transparent would follow them.
- A new address is loaded while the outputs are blanked, then blanking is released. A design that gated the load with the blanking input would bring back the old line.
- The blanking input is toggled between clock edges. A registered blanking path would show up one cycle late.
- Reset is asserted mid-run. A design that cleared the register only on a clock edge would keep showing the old line.

// File: rtl/latdec_pkg.sv
package latdec_pkg;

  // Default address width of the decoder family.
  localparam int unsigned LD_ADDR_W = 4;

  // Operation applied to the address register on a clock edge.
  typedef enum logic [0:0] {
    LATCH_HOLD = 1'b0,
    LATCH_LOAD = 1'b1
  } latch_op_e;

endpackage

// File: rtl/ld_reset_sync.sv
// Asynchronous assertion, synchronous release of the active-low reset.
module ld_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[LAST];

endmodule

// File: rtl/ld_addr_hold.sv
// Address storage: a register with a load enable driven by the strobe.
module ld_addr_hold
  import latdec_pkg::*;
#(
  parameter int unsigned ADDR_W = LD_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [ADDR_W-1:0] addr_d,
  output logic [ADDR_W-1:0] addr_q
);

  latch_op_e         op;
  logic [ADDR_W-1:0] addr_nxt;

  // Next-state process
  always_comb begin
    op = strobe ? LATCH_LOAD : LATCH_HOLD;
    unique case (op)
      LATCH_LOAD: addr_nxt = addr_d;
      default:    addr_nxt = addr_q;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_nxt;
  end

  // R1: a sampled-high strobe loads the address on the bus
  p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (addr_q == $past(addr_d)));

  // R2: a sampled-low strobe leaves the stored address untouched
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(addr_q));

endmodule

// File: rtl/ld_onehot_dec.sv
// Binary to one-hot decode, active-high.
module ld_onehot_dec #(
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned OUT_W = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [OUT_W-1:0]  hot
);

  for (genvar i = 0; i < OUT_W; i++) begin : g_line
    assign hot[i] = (addr == ADDR_W'(i));
  end

endmodule

// File: rtl/ld_out_stage.sv
// Blanking and polarity stage.
module ld_out_stage #(
  parameter int unsigned OUT_W       = 16,
  parameter bit          ACTIVE_HIGH = 1'b1
) (
  input  logic             inhibit,
  input  logic [OUT_W-1:0] hot,
  output logic [OUT_W-1:0] lines
);

  if (ACTIVE_HIGH) begin : g_pos
    always_comb lines = inhibit ? '0 : hot;
  end else begin : g_neg
    always_comb lines = inhibit ? '1 : ~hot;
  end

endmodule

// File: rtl/latched_line_decoder.sv
module latched_line_decoder
  import latdec_pkg::*;
#(
  parameter int unsigned ADDR_W      = LD_ADDR_W,
  parameter bit          ACTIVE_HIGH = 1'b1,
  localparam int unsigned OUT_W      = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              inhibit,
  input  logic [ADDR_W-1:0] sel_addr,
  output logic [OUT_W-1:0]  line_sel
);

  localparam logic ACT_LVL = ACTIVE_HIGH;

  logic              rst_sync_n;
  logic [ADDR_W-1:0] stored_addr;
  logic [OUT_W-1:0]  hot;

  ld_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ld_addr_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .strobe (strobe),
    .addr_d (sel_addr),
    .addr_q (stored_addr)
  );

  ld_onehot_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr (stored_addr),
    .hot  (hot)
  );

  ld_out_stage #(.OUT_W(OUT_W), .ACTIVE_HIGH(ACTIVE_HIGH)) u_out (
    .inhibit (inhibit),
    .hot     (hot),
    .lines   (line_sel)
  );

  // R3: blanking puts every line at the inactive level
  p_blank_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    inhibit |-> (line_sel == {OUT_W{~ACT_LVL}}));

  // R5: without blanking, exactly one line is active
  p_one_active_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !inhibit |-> ($countones(line_sel ^ {OUT_W{~ACT_LVL}}) == 1));

  // R6: the active line index is the stored address value
  p_index_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !inhibit |-> (line_sel[stored_addr] == ACT_LVL));

  // R4: a load during blanking is visible once blanking ends
  p_load_blanked_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (inhibit && strobe) |=> (stored_addr == $past(sel_addr)));

endmodule

// File: tb/latched_line_decoder_tb_top.sv
module latched_line_decoder_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        strobe;
  logic        inhibit;
  logic [3:0]  sel_addr;
  logic [15:0] line_hi;
  logic [15:0] line_lo;

  int n_checks = 0;
  int n_fails  = 0;
  int model_addr = 0;

  logic [15:0] exp_q[$];
  logic        inh_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  latched_line_decoder #(.ACTIVE_HIGH(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .inhibit(inhibit),
    .sel_addr(sel_addr), .line_sel(line_hi)
  );

  latched_line_decoder #(.ACTIVE_HIGH(1'b0)) dut_lo_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .inhibit(inhibit),
    .sel_addr(sel_addr), .line_sel(line_lo)
  );

  function automatic logic [15:0] expect_hi(int a, logic inh);
    return inh ? 16'h0000 : (16'h0001 << a);
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: apply inputs just after a falling edge, optionally check the
  // combinational response before the next rising edge, then push the
  // value expected after that rising edge.
  task automatic step(logic s, logic inh, int a, string tag, bit comb_chk);
    @(negedge clk);
    #1;
    strobe   = s;
    inhibit  = inh;
    sel_addr = 4'(a);
    if (comb_chk) begin
      #1;
      check({"R9 ", tag, " hi"}, line_hi, expect_hi(model_addr, inh));
      check({"R9 ", tag, " lo"}, line_lo, ~expect_hi(model_addr, inh));
    end
    @(posedge clk);
    if (s) model_addr = a;
    exp_q.push_back(expect_hi(model_addr, inh));
    inh_q.push_back(inh);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare both polarities at each falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [15:0] e;
      logic        ih;
      string       t;
      e  = exp_q.pop_front();
      ih = inh_q.pop_front();
      t  = tag_q.pop_front();
      check({t, " hi"}, line_hi, e);
      check({"R7 ", t, " lo"}, line_lo, ~e);
      if (!ih) begin
        n_checks++;
        if ($countones(line_hi) != 1) begin
          n_fails++;
          $display("FAIL R5 %s: actual ones %0d expected 1", t, $countones(line_hi));
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; strobe = 1'b0; inhibit = 1'b0; sel_addr = 4'd0;
    #(CLK_PERIOD * 2 + 2);
    check("R8 reset hi", line_hi, 16'h0001);
    check("R8 reset lo", line_lo, 16'hFFFE);
    @(negedge clk); #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 / R6 / R7: every address, both polarities
    for (int a = 0; a < 16; a++) step(1'b1, 1'b0, a, "R1 R6 sweep", 1'b0);

    // R2: hold while strobe is low
    step(1'b1, 1'b0, 5,  "R2 load", 1'b0);
    step(1'b0, 1'b0, 9,  "R2 hold", 1'b0);
    step(1'b0, 1'b0, 12, "R2 hold", 1'b0);

    // R3 / R9: blanking takes effect between edges
    step(1'b0, 1'b1, 3,  "R3 blank", 1'b1);
    step(1'b0, 1'b0, 3,  "R3 release", 1'b1);

    // R4: loading during blanking, then release
    step(1'b1, 1'b1, 11, "R4 load blanked", 1'b1);
    step(1'b0, 1'b1, 2,  "R4 hold blanked", 1'b0);
    step(1'b0, 1'b0, 7,  "R4 release", 1'b1);

    // R6: bit order corner values
    step(1'b1, 1'b0, 1,  "R6 A only", 1'b0);
    step(1'b1, 1'b0, 8,  "R6 D only", 1'b0);

    // R8: asynchronous reset mid-run
    step(1'b1, 1'b0, 9,  "R8 preload", 1'b0);
    @(negedge clk);
    #1 rst_n = 1'b0;
    strobe = 1'b0;
    #1;
    check("R8 midrun hi", line_hi, 16'h0001);
    check("R8 midrun lo", line_lo, 16'hFFFE);
    model_addr = 0;
    @(negedge clk); #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    step(1'b0, 1'b0, 6, "R8 after reset", 1'b0);

    repeat (2) @(negedge clk);
    #2;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule